// File: doc/BRIEF.md
# Terminal-State PRNG Advance Limiter

This block sits between a key-management main controller and the masking PRNG with its reseed logic. While the controller runs normally, the controller's request to advance the PRNG passes straight through. Requests from other clients, such as a hash-engine application port or key sideload ports, are ORed in. Every advance starts an entropy reseed request when none is pending. The request is held until the entropy source acknowledges it.

The controller can reach one of two terminal states, disabled or invalid. Once either is seen, the block keeps honouring controller advances only until a set number of further reseeds have finished (two by default). After that it blocks the controller's path for good, until reset. The other clients stay ungated, and a handshake already under way is never cut short.

Top module: `prng_quiesce_gate`

## Requirements
- R1: While reset is held and directly after it, `ent_req_o` is 0 and the block is in the non-terminal phase, so a controller advance passes through.
- R2: Before any terminal state has been seen, `prng_adv_o` equals `ctrl_adv_i` ORed with every bit of `client_adv_i` (one bit per client) in the same cycle.
- R3: An advance on `prng_adv_o` while `ent_req_o` is 0 sets `ent_req_o` to 1 in the next cycle. It then stays 1 until `ent_ack_i` is sampled high, and falls in the cycle after that.
- R4: `ent_ack_i` sampled while `ent_req_o` is 0 has no effect: it neither counts as a reseed nor changes `ent_req_o`.
- R5: `term_disabled_i` and `term_invalid_i` each start the limiting behaviour on their own, with the same result.
- R6: After terminal entry, controller advances are honoured until RESEED_LIMIT reseeds (request high and acknowledge sampled) have completed. From the next cycle on, the controller path is blocked.
- R7: A reseed completing before terminal entry does not count. One completing in the entry cycle itself does count.
- R8: Terminal entry is sticky. Dropping both terminal inputs neither restarts the count nor unblocks the controller; only reset does.
- R9: `client_adv_i` bits still drive `prng_adv_o` and still start reseeds after the controller path is blocked.
- R10: A reseed request raised after blocking is held and released by its acknowledge exactly as in R3.
- R11: The completed-reseed count saturates at RESEED_LIMIT. Further completions never wrap it and never re-open the controller path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| term_disabled_i | input | 1 | Controller is in its disabled terminal state |
| term_invalid_i | input | 1 | Controller is in its invalid terminal state |
| ctrl_adv_i | input | 1 | Controller's PRNG advance request |
| client_adv_i | input | NUM_CLIENTS | Advance requests from other clients, one bit each |
| ent_ack_i | input | 1 | Entropy acknowledge for the reseed request |
| prng_adv_o | output | 1 | Combined PRNG advance enable |
| ent_req_o | output | 1 | Reseed entropy request |

## Verification
The collision that matters is terminal entry falling in the same cycle as a reseed completion. The bench leaves a controller-started request pending, then raises a terminal input in the very cycle it drives the acknowledge, with a sweep over both terminal inputs and over zero to two earlier completions. It judges the result by counting how many later controller advances still reach `prng_adv_o`: one fewer than RESEED_LIMIT when the entry-cycle completion counted, and exactly RESEED_LIMIT when no acknowledge coincided. A second collision, a blocked controller advance in the same cycle as a client advance, is judged at `prng_adv_o` and `ent_req_o` one cycle later.

// File: rtl/pqg_pkg.sv
package pqg_pkg;

  // Gate phase: no terminal state yet, counting reseeds, controller sealed off
  typedef enum logic [1:0] {
    PQG_LIVE   = 2'b00,
    PQG_WINDOW = 2'b01,
    PQG_SEALED = 2'b10
  } pqg_phase_e;

  function automatic int unsigned pqg_cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/pqg_term_tally.sv
module pqg_term_tally
  import pqg_pkg::*;
#(
  parameter int unsigned RESEED_LIMIT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic term_any_i,
  input  logic reseed_done_i,
  output logic ctrl_block_o
);

  localparam int unsigned CW = pqg_cnt_width(RESEED_LIMIT);
  localparam logic [CW-1:0] LIMIT_V = CW'(RESEED_LIMIT);

  pqg_phase_e    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          terminal_now;
  logic          count_en;

  assign terminal_now = term_any_i | (phase_q != PQG_LIVE);
  assign count_en     = terminal_now & reseed_done_i & (phase_q != PQG_SEALED);

  always_comb begin
    cnt_d = cnt_q;
    if (count_en) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_comb begin
    phase_d = phase_q;
    if (terminal_now) begin
      if (cnt_d == LIMIT_V) begin
        phase_d = PQG_SEALED;
      end else begin
        phase_d = PQG_WINDOW;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PQG_LIVE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (count_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign ctrl_block_o = (phase_q == PQG_SEALED);

  AST_PHASE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PQG_LIVE) |=> (phase_q != PQG_LIVE)); // R8
  AST_SEAL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PQG_SEALED) |=> (phase_q == PQG_SEALED)); // R8
  AST_LIVE_NO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PQG_LIVE) |-> (cnt_q == '0)); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reseed_done_i |=> $stable(cnt_q)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT_V); // R11
  AST_SEAL_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PQG_SEALED) |-> (cnt_q == LIMIT_V)); // R6

endmodule

// File: rtl/pqg_ent_hs.sv
module pqg_ent_hs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic ack_i,
  output logic req_o,
  output logic done_o
);

  logic req_q, req_d;

  always_comb begin
    if (req_q) begin
      req_d = ~ack_i;
    end else begin
      req_d = adv_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign req_o  = req_q;
  assign done_o = req_q & ack_i;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> req_o); // R3
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !req_o); // R3
  AST_REQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_o && adv_i) |=> req_o); // R3
  AST_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_o && !adv_i) |=> !req_o); // R4

endmodule

// File: rtl/pqg_adv_merge.sv
module pqg_adv_merge #(
  parameter int unsigned NUM_CLIENTS = 2
) (
  input  logic                   ctrl_adv_i,
  input  logic                   ctrl_block_i,
  input  logic [NUM_CLIENTS-1:0] client_adv_i,
  output logic                   adv_o
);

  logic [NUM_CLIENTS:0] or_chain;

  assign or_chain[0] = ctrl_adv_i & ~ctrl_block_i;

  for (genvar i = 0; i < NUM_CLIENTS; i++) begin : g_client
    assign or_chain[i+1] = or_chain[i] | client_adv_i[i];
  end

  assign adv_o = or_chain[NUM_CLIENTS];

endmodule

// File: rtl/prng_quiesce_gate.sv
module prng_quiesce_gate #(
  parameter int unsigned NUM_CLIENTS  = 2,
  parameter int unsigned RESEED_LIMIT = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   term_disabled_i,
  input  logic                   term_invalid_i,
  input  logic                   ctrl_adv_i,
  input  logic [NUM_CLIENTS-1:0] client_adv_i,
  input  logic                   ent_ack_i,
  output logic                   prng_adv_o,
  output logic                   ent_req_o
);

  logic term_any;
  logic ctrl_block;
  logic reseed_done;

  assign term_any = term_disabled_i | term_invalid_i;

  pqg_term_tally #(
    .RESEED_LIMIT (RESEED_LIMIT)
  ) u_tally (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .term_any_i    (term_any),
    .reseed_done_i (reseed_done),
    .ctrl_block_o  (ctrl_block)
  );

  pqg_adv_merge #(
    .NUM_CLIENTS (NUM_CLIENTS)
  ) u_merge (
    .ctrl_adv_i   (ctrl_adv_i),
    .ctrl_block_i (ctrl_block),
    .client_adv_i (client_adv_i),
    .adv_o        (prng_adv_o)
  );

  pqg_ent_hs u_hs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (prng_adv_o),
    .ack_i  (ent_ack_i),
    .req_o  (ent_req_o),
    .done_o (reseed_done)
  );

  AST_CTRL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_adv_i && !ctrl_block) |-> prng_adv_o); // R2
  AST_CLIENT_UNGATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|client_adv_i) |-> prng_adv_o); // R9
  AST_BLOCKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_block && !(|client_adv_i)) |-> !prng_adv_o); // R6

endmodule

// File: tb/sim_prng_quiesce_gate.sv
module sim_prng_quiesce_gate;

  localparam int NC  = 2;
  localparam int LIM = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          term_disabled_i, term_invalid_i, ctrl_adv_i, ent_ack_i;
  logic [NC-1:0] client_adv_i;
  logic          prng_adv_o, ent_req_o;

  always #2 clk_i = ~clk_i;

  prng_quiesce_gate #(.NUM_CLIENTS(NC), .RESEED_LIMIT(LIM)) u0 (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .term_disabled_i (term_disabled_i),
    .term_invalid_i  (term_invalid_i),
    .ctrl_adv_i      (ctrl_adv_i),
    .client_adv_i    (client_adv_i),
    .ent_ack_i       (ent_ack_i),
    .prng_adv_o      (prng_adv_o),
    .ent_req_o       (ent_req_o)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string tag = "R1";

  // expectation state derived from the requirements
  bit m_seen;
  int m_cnt;
  bit m_req;
  bit g;

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    term_disabled_i = 0; term_invalid_i = 0; ctrl_adv_i = 0;
    ent_ack_i = 0; client_adv_i = '0;
    repeat (3) @(negedge clk_i);
    chk(ent_req_o, 0, "ent_req_o during reset");
    rst_ni = 1'b1;
    m_seen = 0; m_cnt = 0; m_req = 0;
  endtask

  // One cycle, starting and ending at a falling edge
  task automatic cyc(input bit c, input logic [NC-1:0] cl, input bit ack,
                     input bit dis, input bit inv, output bit got);
    bit blk, eadv, done, term;
    chk(ent_req_o, m_req, "ent_req_o");
    ctrl_adv_i = c; client_adv_i = cl; ent_ack_i = ack;
    term_disabled_i = dis; term_invalid_i = inv;
    #1;
    blk  = (m_cnt >= LIM);
    eadv = (c && !blk) || (|cl);
    got  = prng_adv_o;
    chk(prng_adv_o, eadv, "prng_adv_o");
    @(posedge clk_i);
    done = m_req && ack;
    term = dis || inv || m_seen;
    if (term && done && m_cnt < LIM) m_cnt++;
    if (dis || inv) m_seen = 1;
    m_req = m_req ? !ack : eadv;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    // R1: reset state
    tag = "R1";
    do_reset();
    chk(ent_req_o, 0, "ent_req_o after reset");
    cyc(1, '0, 0, 0, 0, g);
    chk(g, 1, "ctrl advance passes after reset");

    // R2: sweep every input pattern before terminal entry
    tag = "R2";
    do_reset();
    for (int p = 0; p < (1 << (NC + 1)); p++) begin
      logic [NC:0] pv;
      pv = p[NC:0];
      cyc(pv[0], pv[NC:1], 1, 0, 0, g);
      cyc(pv[0], pv[NC:1], 0, 0, 0, g);
    end

    // R3: request raised, held while unacknowledged, dropped after ack
    tag = "R3";
    do_reset();
    cyc(1, '0, 0, 0, 0, g);
    for (int k = 0; k < 4; k++) cyc(k[0], '0, 0, 0, 0, g);
    cyc(0, '0, 1, 0, 0, g);
    cyc(0, '0, 0, 0, 0, g);
    chk(ent_req_o, 0, "request cleared after ack");

    // R4: stray acks in terminal state do not count
    tag = "R4";
    do_reset();
    for (int k = 0; k < 4; k++) cyc(0, '0, 1, 1, 0, g);
    begin
      int hon;
      hon = 0;
      for (int k = 0; k < 4; k++) begin
        cyc(1, '0, 0, 1, 0, g); hon += g;
        cyc(0, '0, 1, 1, 0, g);
      end
      chk(hon, LIM, "honoured ctrl advances after stray acks");
    end

    // R5/R6/R7: both terminal inputs, prior completions, ack at entry
    for (int path = 0; path < 2; path++) begin
      for (int pre = 0; pre < 3; pre++) begin
        for (int ae = 0; ae < 2; ae++) begin
          int hon;
          bit d, i;
          d = (path == 0); i = (path == 1);
          tag = "R7";
          do_reset();
          for (int k = 0; k < pre; k++) begin
            cyc(1, '0, 0, 0, 0, g);
            cyc(0, '0, 1, 0, 0, g);
          end
          cyc(1, '0, 0, 0, 0, g);
          tag = "R5";
          cyc(0, '0, ae[0], d, i, g);
          tag = "R6";
          hon = 0;
          for (int k = 0; k < 4; k++) begin
            cyc(1, '0, 0, d, i, g); hon += g;
            cyc(0, '0, 1, d, i, g);
          end
          chk(hon, LIM - ae, "R7 honoured ctrl advances after entry");
        end
      end
    end

    // R8: terminal inputs dropped, controller stays blocked
    tag = "R8";
    for (int k = 0; k < 3; k++) begin
      cyc(1, '0, 0, 0, 0, g);
      chk(g, 0, "ctrl still blocked after terminal inputs drop");
    end

    // R9/R10/R11: clients keep working, handshake intact, no wrap
    for (int r = 0; r < 3; r++) begin
      tag = "R9";
      cyc(1, NC'(r + 1), 0, 0, 0, g);
      chk(g, 1, "client advance ungated");
      tag = "R10";
      cyc(1, '0, 0, 0, 0, g);
      cyc(0, '0, 0, 0, 0, g);
      chk(ent_req_o, 1, "client request held");
      cyc(0, '0, 1, 0, 0, g);
      tag = "R11";
      cyc(1, '0, 0, 0, 0, g);
      chk(g, 0, "ctrl blocked after extra completions");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule